// File: doc/BRIEF.md
# Machine Timer Interrupt Generator

This block holds a 64-bit free-running machine timer and a 64-bit compare value for a small 32-bit core, and turns the relation between the two into the machine timer interrupt. On each `tick` strobe, the timer advances by the sampled elapsed-time amount. Every cycle, the block re-evaluates whether the timer has moved strictly past the compare value. If it has, the block raises a registered timer-pending bit and asks the core to leave its wait-for-interrupt sleep.

The core supplies its timer-enable bit and its global interrupt-enable bit. The block combines them with the pending bit into a one-cycle-per-cycle take strobe with the interrupt cause code. It also tells the core whether it may execute instructions while the sleep flag is set. The compare register is written one 32-bit half at a time. A compare value of zero disarms the interrupt completely.

Top module: `mtimer_irq_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `time_lo`, `time_hi`, `cmp_lo`, `cmp_hi` and `timer_pend` all read zero, and `take_irq` is low, until the first tick or compare write.
- R2: In a cycle with `tick` high, the rising edge adds `elapsed` to `time_lo`. A carry out of bit 31 increments `time_hi`, which wraps modulo 2^32. In a cycle with `tick` low, both halves hold.
- R3: `cmp_lo_we` loads `cmp_wdata` into `cmp_lo`, and `cmp_hi_we` loads it into `cmp_hi`, at the next rising edge. Each half is independent, and both may be written in the same cycle.
- R4: `timer_pend` is a register. After each edge it equals 1 exactly when the 64-bit timer {time_hi,time_lo} was strictly greater than {cmp_hi,cmp_lo} during the preceding cycle. Equality gives 0.
- R5: When the compare value is all zeros, `timer_pend` becomes 0 at the next edge, whatever the timer value.
- R6: `sleep_clr` is high in every cycle in which `timer_pend` is high, and low otherwise.
- R7: `take_irq` is high only when `timer_pend`, `mtie` and `gmie` are all high. While it is high, `take_cause` is 32'h8000_0007, with bit 31 marking an interrupt and the low bits holding cause 7. Otherwise `take_cause` is zero.
- R8: `core_run` is low exactly when `sleep_in` is high and `timer_pend` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer advance strobe |
| elapsed | input | 32 | Amount added to the timer on a tick |
| cmp_lo_we | input | 1 | Write strobe for the low compare half |
| cmp_hi_we | input | 1 | Write strobe for the high compare half |
| cmp_wdata | input | 32 | Compare write data |
| mtie | input | 1 | Timer interrupt enable bit from the core |
| gmie | input | 1 | Global machine interrupt enable from the core |
| sleep_in | input | 1 | Core is in wait-for-interrupt sleep |
| time_lo | output | 32 | Timer low half |
| time_hi | output | 32 | Timer high half |
| cmp_lo | output | 32 | Compare low half |
| cmp_hi | output | 32 | Compare high half |
| timer_pend | output | 1 | Registered timer-pending bit |
| sleep_clr | output | 1 | Request to clear the sleep flag |
| core_run | output | 1 | Core may execute instructions |
| take_irq | output | 1 | Timer interrupt is taken this cycle |
| take_cause | output | 32 | Cause code accompanying `take_irq` |

## Verification
Two events can fall in the same cycle: a tick whose low-half addition carries into the high half, and a compare write that moves the threshold across the timer. The bench provokes this by parking the compare value a few counts above the timer and then issuing large elapsed values together with half writes. It also drives the exact-equality and zero-compare edges.

A bench model advances its own timer and compare value and computes the registered pending bit from the state before each edge. It then judges the outputs, including the take strobe and the run permission, against the enable and sleep inputs driven in that cycle.

// File: rtl/mtimer_pkg.sv
// Shared constants for the machine timer interrupt generator.
// Assumes a 32-bit core: cause codes are one data word wide.
package mtimer_pkg;
    localparam int unsigned HALF_W     = 32;
    localparam int unsigned CAUSE_W    = 32;
    localparam int unsigned TIMER_CODE = 7;
    localparam logic [CAUSE_W-1:0] TIMER_CAUSE =
        {1'b1, {(CAUSE_W-1-4){1'b0}}, 4'(TIMER_CODE)};
endpackage

// File: rtl/mtimer_count.sv
// Two-half machine timer. Adds the elapsed amount to the low half on a
// tick and ripples the carry into the high half. Assumes elapsed is
// stable in the tick cycle.
module mtimer_count #(
    parameter int unsigned HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [HW-1:0] elapsed,
    output logic [HW-1:0] cnt_lo,
    output logic [HW-1:0] cnt_hi
);
    logic [HW:0] lo_sum;

    // Low-half sum with carry out
    always_comb lo_sum = {1'b0, cnt_lo} + {1'b0, elapsed};

    // Advance both halves on a tick, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (tick) begin
            cnt_lo <= lo_sum[HW-1:0];
            cnt_hi <= cnt_hi + HW'(lo_sum[HW]);
        end
    end
endmodule

// File: rtl/mtimer_cmp_reg.sv
// Compare register written one half at a time. Assumes both halves
// share a single write data bus; either or both may load in one cycle.
module mtimer_cmp_reg #(
    parameter int unsigned HW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_lo,
    input  logic            we_hi,
    input  logic [HW-1:0]   wdata,
    output logic [2*HW-1:0] cmp
);
    localparam int unsigned NHALF = 2;
    logic [NHALF-1:0] we;

    // Gather per-half strobes, low half at index 0
    always_comb we = {we_hi, we_lo};

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        // Load one half of the threshold
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp[g*HW +: HW] <= '0;
            else if (we[g])
                cmp[g*HW +: HW] <= wdata;
        end
    end
endmodule

// File: rtl/mtimer_gt.sv
// Strict greater-than between timer and compare, evaluated high half
// first. A compare value of all zeros disarms the result.
module mtimer_gt #(
    parameter int unsigned HW = 32
) (
    input  logic [HW-1:0] t_lo,
    input  logic [HW-1:0] t_hi,
    input  logic [HW-1:0] c_lo,
    input  logic [HW-1:0] c_hi,
    output logic          fire
);
    logic hi_gt, hi_eq, lo_gt, armed;

    // Split comparison and arming
    always_comb begin
        hi_gt = t_hi > c_hi;
        hi_eq = t_hi == c_hi;
        lo_gt = t_lo > c_lo;
        armed = |{c_hi, c_lo};
        fire  = armed & (hi_gt | (hi_eq & lo_gt));
    end
endmodule

// File: rtl/mtimer_irq_gen.sv
// Machine timer interrupt generator top. Registers the pending bit from
// the timer/compare relation every cycle, requests wake from sleep, gates
// the take strobe with the core's enables and reports the cause code.
// Assumes mtie/gmie/sleep_in come straight from core state registers.
module mtimer_irq_gen #(
    parameter int unsigned HW = mtimer_pkg::HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [HW-1:0] elapsed,
    input  logic          cmp_lo_we,
    input  logic          cmp_hi_we,
    input  logic [HW-1:0] cmp_wdata,
    input  logic          mtie,
    input  logic          gmie,
    input  logic          sleep_in,
    output logic [HW-1:0] time_lo,
    output logic [HW-1:0] time_hi,
    output logic [HW-1:0] cmp_lo,
    output logic [HW-1:0] cmp_hi,
    output logic          timer_pend,
    output logic          sleep_clr,
    output logic          core_run,
    output logic          take_irq,
    output logic [mtimer_pkg::CAUSE_W-1:0] take_cause
);
    logic [2*HW-1:0] cmp_q;
    logic            fire;

    mtimer_count #(.HW(HW)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .elapsed(elapsed),
        .cnt_lo(time_lo), .cnt_hi(time_hi)
    );

    mtimer_cmp_reg #(.HW(HW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .we_lo(cmp_lo_we), .we_hi(cmp_hi_we),
        .wdata(cmp_wdata), .cmp(cmp_q)
    );

    // Expose compare halves
    always_comb begin
        cmp_lo = cmp_q[HW-1:0];
        cmp_hi = cmp_q[2*HW-1:HW];
    end

    mtimer_gt #(.HW(HW)) u_gt (
        .t_lo(time_lo), .t_hi(time_hi), .c_lo(cmp_lo), .c_hi(cmp_hi),
        .fire(fire)
    );

    // Pending bit re-evaluated each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) timer_pend <= 1'b0;
        else        timer_pend <= fire;
    end

    // Wake, run permission and take strobe
    always_comb begin
        sleep_clr  = timer_pend;
        core_run   = ~sleep_in | timer_pend;
        take_irq   = timer_pend & mtie & gmie;
        take_cause = take_irq ? mtimer_pkg::TIMER_CAUSE : '0;
    end
endmodule

// File: rtl/mtimer_irq_gen_chk.sv
// Property checker for mtimer_irq_gen, attached by bind below.
module mtimer_irq_gen_chk #(
    parameter int unsigned HW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [HW-1:0] elapsed,
    input logic          cmp_lo_we,
    input logic [HW-1:0] cmp_wdata,
    input logic          mtie,
    input logic          gmie,
    input logic          sleep_in,
    input logic [HW-1:0] time_lo,
    input logic [HW-1:0] time_hi,
    input logic [HW-1:0] cmp_lo,
    input logic [HW-1:0] cmp_hi,
    input logic          timer_pend,
    input logic          sleep_clr,
    input logic          core_run,
    input logic          take_irq,
    input logic [31:0]   take_cause
);
    logic [HW:0] lo_sum;
    always_comb lo_sum = {1'b0, time_lo} + {1'b0, elapsed};

    a_r2_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lo_sum[HW]) |=> time_hi == $past(time_hi) + 1'b1);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(time_lo) && $stable(time_hi));
    a_r3_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_lo_we |=> cmp_lo == $past(cmp_wdata));
    a_r4_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (time_lo == cmp_lo && time_hi == cmp_hi) |=> !timer_pend);
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo == '0 && cmp_hi == '0) |=> !timer_pend);
    a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
        timer_pend |-> sleep_clr);
    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> timer_pend && mtie && gmie);
    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> take_cause == 32'h8000_0007);
    a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_in && !timer_pend) |-> !core_run);
endmodule

bind mtimer_irq_gen mtimer_irq_gen_chk #(.HW(HW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .elapsed(elapsed),
    .cmp_lo_we(cmp_lo_we), .cmp_wdata(cmp_wdata), .mtie(mtie),
    .gmie(gmie), .sleep_in(sleep_in), .time_lo(time_lo),
    .time_hi(time_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .timer_pend(timer_pend), .sleep_clr(sleep_clr), .core_run(core_run),
    .take_irq(take_irq), .take_cause(take_cause)
);

// File: tb/mtimer_irq_gen_bench.sv
// Self-checking bench: reference model of timer, compare and pending bit,
// random stimulus with fixed seed plus directed corners.
module mtimer_irq_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] elapsed = '0;
    logic        cmp_lo_we = 1'b0, cmp_hi_we = 1'b0;
    logic [31:0] cmp_wdata = '0;
    logic        mtie = 1'b0, gmie = 1'b0, sleep_in = 1'b0;
    logic [31:0] time_lo, time_hi, cmp_lo, cmp_hi, take_cause;
    logic        timer_pend, sleep_clr, core_run, take_irq;

    int n_chk = 0, n_bad = 0;
    logic [63:0] m_time = '0, m_cmp = '0;
    logic        m_pend = 1'b0;

    always #10 clk = ~clk;

    mtimer_irq_gen u_mtimer_irq_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .elapsed(elapsed),
        .cmp_lo_we(cmp_lo_we), .cmp_hi_we(cmp_hi_we), .cmp_wdata(cmp_wdata),
        .mtie(mtie), .gmie(gmie), .sleep_in(sleep_in),
        .time_lo(time_lo), .time_hi(time_hi), .cmp_lo(cmp_lo),
        .cmp_hi(cmp_hi), .timer_pend(timer_pend), .sleep_clr(sleep_clr),
        .core_run(core_run), .take_irq(take_irq), .take_cause(take_cause)
    );

    function automatic logic exp_fire(logic [63:0] t, logic [63:0] c);
        return (c != 64'd0) && (t > c);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One cycle: check state, drive inputs, check combinational outputs,
    // then advance the model across the coming edge.
    task automatic step(logic tk, logic [31:0] el, logic wlo, logic whi,
                        logic [31:0] wd, logic ie, logic gie, logic sl);
        @(negedge clk);
        chk("R2 timer", {time_hi, time_lo}, m_time);
        chk("R3 compare", {cmp_hi, cmp_lo}, m_cmp);
        chk("R4/R5 pending", 64'(timer_pend), 64'(m_pend));
        tick = tk; elapsed = el; cmp_lo_we = wlo; cmp_hi_we = whi;
        cmp_wdata = wd; mtie = ie; gmie = gie; sleep_in = sl;
        #1;
        chk("R6 sleep_clr", 64'(sleep_clr), 64'(m_pend));
        chk("R8 core_run", 64'(core_run), 64'(!sl || m_pend));
        chk("R7 take_irq", 64'(take_irq), 64'(m_pend && ie && gie));
        chk("R7 take_cause", 64'(take_cause),
            (m_pend && ie && gie) ? 64'h8000_0007 : 64'd0);
        m_pend = exp_fire(m_time, m_cmp);
        if (tk) begin
            m_time[31:0]  = m_time[31:0] + el;
            m_time[63:32] = m_time[63:32] + 32'({1'b0, m_time[31:0]} < {1'b0, el} ? 1 : 0);
        end
        if (wlo) m_cmp[31:0]  = wd;
        if (whi) m_cmp[63:32] = wd;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 timer", {time_hi, time_lo}, 64'd0);
        chk("R1 compare", {cmp_hi, cmp_lo}, 64'd0);
        chk("R1 pend", 64'(timer_pend), 64'd0);
        chk("R1 take", 64'(take_irq), 64'd0);
        rst_n = 1'b1;
        // R5: zero compare never pends, even with large timer
        step(1, 32'hFFFF_FFF0, 0, 0, 0, 1, 1, 1);
        step(1, 32'h20, 0, 0, 0, 1, 1, 1);      // carry into high half
        step(0, 0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 1, 1, 0);
        // R4: compare = timer + 5, then reach equality, then pass it
        step(0, 0, 1, 1, 32'h1, 1, 1, 1);       // both halves same cycle
        step(0, 0, 1, 0, 32'h15, 1, 1, 1);
        step(1, 5, 0, 0, 0, 1, 1, 1);           // equal now
        step(0, 0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 1, 1, 1);
        step(1, 1, 0, 0, 0, 1, 1, 1);           // strictly greater
        step(0, 0, 0, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0, 1, 1, 1);
        // R5: disarm by zeroing compare while pending
        step(0, 0, 1, 1, 32'h0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 1, 1, 1);
        // carry and threshold write in the same cycle
        step(0, 0, 1, 0, 32'hFFFF_FFF8, 1, 1, 0);
        step(0, 0, 0, 1, 32'h1, 1, 1, 0);
        step(1, 32'hFFFF_FFF0, 0, 1, 32'h2, 1, 1, 1);
        step(0, 0, 0, 0, 0, 1, 1, 1);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic        tk, wl, wh, ie, gie, sl;
            logic [31:0] el, wd;
            logic [2:0]  sel;
            tk  = ($urandom % 10) < 7;
            sel = 3'($urandom % 8);
            el  = (sel == 0) ? $urandom : (sel == 1) ? (32'hFFFF_FFFF - 32'($urandom % 64)) : 32'($urandom % 256);
            wl  = ($urandom % 10) == 0;
            wh  = ($urandom % 16) == 0;
            wd  = wl ? (m_time[31:0] + 32'($urandom % 512)) :
                       (m_time[63:32] + 32'($urandom % 2));
            if (($urandom % 50) == 0) wd = 32'd0;
            ie  = ($urandom % 4) != 0;
            gie = ($urandom % 4) != 0;
            sl  = ($urandom % 2) == 0;
            step(tk, el, wl, wh, wd, ie, gie, sl);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule